// File: doc/BRIEF.md
# Battery-Backed Static Memory Strobe Front End

This block sits between an asynchronous byte-wide memory bus and a behavioural byte array. It samples three active-low strobes (chip select, write strobe, output strobe), the address, the write data and a write-protect flag from a power supervisor on a fast system clock. Each of these passes through a two-flop synchroniser. From the synchronised values it decides, one clock at a time, whether a read or a write cycle is in progress. It drives a byte-wide read-data bus together with a drive-enable that an external tri-state pad uses.

A write window is the overlap of chip select and write strobe. The window opens when the later of the two becomes active and closes when the earlier of the two is released. The byte is stored only when the window closes. The output drive follows the ordering rules of an asynchronous static memory. A write strobe silences the drivers. A cycle that starts with the write strobe already active keeps the drivers off until chip select is released. While the supervisor asserts protect, every strobe is ignored and the bus floats. A write that protect interrupts is thrown away.

The array depth is 2^ADDR_W bytes. The full-size configuration sets ADDR_W = 15, which gives 32768 bytes. The default parameter value is smaller so that the array stays cheap to elaborate.

Top module: `nvsram_front`

## Requirements
- R1: The array holds 2^ADDR_W bytes, each addressed by `addr`. A byte written at an address is read back unchanged, and writes to other addresses do not disturb it.
- R2: `dout_oe` is 1 only while chip select and output strobe are both low, the write strobe is high and protect is low. While `dout_oe` is 1, `dout` carries the byte stored at `addr`. While `dout_oe` is 0, `dout` is 0.
- R3: A write occurs only in the overlap of chip select low and write strobe low. The overlap may begin with either strobe or with both together, and may end with either strobe. The stored byte and address are the values present in the last sampled clock of the overlap, so a `din` change after the overlap closes has no effect.
- R4: Driving the write strobe low during an active read turns `dout_oe` off. If chip select went low before the write strobe, `dout_oe` returns when the write strobe is released while chip select and output strobe remain low.
- R5: If the write strobe is already low when chip select goes low, or goes low in the same sampled clock, `dout_oe` stays 0 until chip select is released, even after the write strobe returns high.
- R6: While `wprot` is 1, `dout_oe` is 0 and no strobe activity changes the array.
- R7: A write overlap that is open when `wprot` rises is aborted. The array is not updated, even if `wprot` falls again before the strobes are released.
- R8: After reset, `dout_oe` is 0 and `dout` is 0.
- R9: A change on the strobes reaches `dout_oe` on the third rising clock edge after it is set up. That is two synchroniser stages followed by one output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| wprot | input | 1 | Write protect from the power supervisor, active high |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data from the bus |
| dout | output | DATA_W | Read data towards the pad |
| dout_oe | output | 1 | Pad drive enable, 1 = drive |

## Verification
The bench compares two ways of starting a cycle that has the output strobe active. When chip select leads, a design that ignored the ordering would keep the drivers off after the write strobe is released, or would drive during the write. When the write strobe leads, a design that lacked the ordering rule would start driving as soon as the write strobe rose. The bench also changes the data after the write strobe closes the window but while chip select is still low; a design that captured data at chip-select release would store the late byte. Finally, it interrupts an open write with protect, lowers protect again, and only then releases the strobes. A design without abort tracking would write the byte when protect fell.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;

    // Decoded strobes after synchronisation, all active high.
    typedef struct packed {
        logic sel;
        logic wr;
        logic rd;
        logic prot;
    } strobe_t;

    localparam int STROBE_W = $bits(strobe_t);

endpackage

// File: rtl/nvsram_sync.sv
module nvsram_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = async_i;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_o = s_q.stable;

endmodule

// File: rtl/nvsram_array.sv
module nvsram_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

    // R1: a store always targets a defined location
    a_r1_store_addr_known: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$isunknown(wr_addr));

endmodule

// File: rtl/nvsram_cycle.sv
module nvsram_cycle
    import nvsram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strobe_t           stb,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_din,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);

    typedef struct packed {
        logic              sel_prev;
        logic              win;
        logic              abort;
        logic              mute;
        logic              commit;
        logic              drive;
        logic [ADDR_W-1:0] wa;
        logic [DATA_W-1:0] wd;
        logic [DATA_W-1:0] rdat;
    } cyc_t;

    cyc_t c_d, c_q;
    logic overlap;
    logic open_now;

    always_comb begin
        c_d          = c_q;
        overlap      = stb.sel & stb.wr;
        // any overlap touched by protect stays void until a strobe releases
        c_d.abort    = overlap & (c_q.abort | stb.prot);
        open_now     = overlap & ~stb.prot & ~c_q.abort;
        c_d.win      = open_now;
        if (open_now) begin
            c_d.wa = bus_addr;
            c_d.wd = bus_din;
        end
        c_d.commit   = c_q.win & ~open_now & ~stb.prot;
        // write strobe leading or tied with select mutes the whole select cycle
        c_d.mute     = stb.sel & (c_q.mute | (~c_q.sel_prev & stb.wr));
        c_d.sel_prev = stb.sel;
        c_d.drive    = stb.sel & stb.rd & ~stb.wr & ~stb.prot & ~c_d.mute;
        c_d.rdat     = c_d.drive ? rd_data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rd_addr = bus_addr;
    assign wr_en   = c_q.commit;
    assign wr_addr = c_q.wa;
    assign wr_data = c_q.wd;
    assign dout    = c_q.rdat;
    assign dout_oe = c_q.drive;

    // R4: an active write strobe silences the drivers on the next clock
    a_r4_wr_mutes: assert property (@(posedge clk) disable iff (!rst_n)
        stb.wr |=> !dout_oe);

    // R6: protect floats the bus on the next clock
    a_r6_prot_floats: assert property (@(posedge clk) disable iff (!rst_n)
        stb.prot |=> !dout_oe);

    // R3: each closed window yields exactly one store pulse
    a_r3_single_store: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.commit |=> !c_q.commit);

    // R5: a muted select cycle never drives
    a_r5_mute_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.mute |-> !dout_oe);

    // R7: an aborted overlap never holds an open window
    a_r7_abort_closed: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.abort |-> !c_q.win);

    // R2: drive only follows a sampled select with output strobe
    a_r2_drive_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> $past(stb.sel && stb.rd));

endmodule

// File: rtl/nvsram_front.sv
module nvsram_front
    import nvsram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              wprot,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);

    localparam int SYNC_W = STROBE_W + ADDR_W + DATA_W;

    logic [SYNC_W-1:0] raw_vec;
    logic [SYNC_W-1:0] sync_vec;
    strobe_t           stb;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_din;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    assign raw_vec = {~cs_n, ~we_n, ~oe_n, wprot, addr, din};

    nvsram_sync #(.W(SYNC_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_vec),
        .sync_o  (sync_vec)
    );

    assign {stb, s_addr, s_din} = sync_vec;

    nvsram_cycle #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cycle (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (stb),
        .bus_addr (s_addr),
        .bus_din  (s_din),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

    nvsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: tb/nvsram_front_bench.sv
module nvsram_front_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 11;
    localparam int DW         = 8;
    localparam int POOL       = 16;
    localparam int WATCHDOG   = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, wprot = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [DW-1:0] model [1<<AW];
    logic [AW-1:0] pool  [POOL];

    always #(CLK_PERIOD/2) clk = ~clk;

    nvsram_front #(.ADDR_W(AW), .DATA_W(DW)) u_nvsram_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .wprot(wprot), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // order: 0 select leads, 1 write strobe leads, 2 together; rel: which releases first
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input int order, input int rel);
        addr = a; din = d; oe_n = 1'b1;
        if (order == 0) begin cs_n = 1'b0; step(2); we_n = 1'b0; end
        else if (order == 1) begin we_n = 1'b0; step(2); cs_n = 1'b0; end
        else begin cs_n = 1'b0; we_n = 1'b0; end
        step(4);
        if (rel == 0) we_n = 1'b1; else cs_n = 1'b1;
        step(2);
        cs_n = 1'b1; we_n = 1'b1;
        step(4);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        addr = a; cs_n = 1'b0; oe_n = 1'b0;
        step(5);
        check({req, " drive"}, 32'(dout_oe), 32'd1);
        check({req, " data"}, 32'(dout), 32'(exp));
        cs_n = 1'b1; oe_n = 1'b1;
        step(4);
        check({req, " release"}, 32'(dout_oe), 32'd0);
    endtask

    function automatic logic [DW-1:0] next_byte(input logic [DW-1:0] b);
        return b ^ 8'h5A;
    endfunction

    initial begin
        void'($urandom(32'h1D5A_0C3F));
        step(3);
        // R8: reset state
        check("R8 oe at reset", 32'(dout_oe), 32'd0);
        check("R8 dout at reset", 32'(dout), 32'd0);
        rst_n = 1'b1;
        step(3);

        // R1: fill the pool with distinct addresses
        for (int i = 0; i < POOL; i++) begin
            pool[i] = AW'(i * 97 + 5);
            model[pool[i]] = DW'($urandom);
            do_write(pool[i], model[pool[i]], i % 3, i % 2);
        end
        for (int i = 0; i < POOL; i++) do_read(pool[i], model[pool[i]], "R1 readback");

        // R9: latency of the drive enable
        addr = pool[0]; cs_n = 1'b0; oe_n = 1'b0;
        step(2);
        check("R9 not yet at 2 edges", 32'(dout_oe), 32'd0);
        step(1);
        check("R9 on at 3rd edge", 32'(dout_oe), 32'd1);
        // R4: write strobe silences, returns on release (select led)
        din = 8'hC3; we_n = 1'b0;
        step(5);
        check("R4 muted by write strobe", 32'(dout_oe), 32'd0);
        we_n = 1'b1;
        step(5);
        model[pool[0]] = 8'hC3;
        check("R4 drive returns", 32'(dout_oe), 32'd1);
        check("R4 data is new byte", 32'(dout), 32'hC3);
        cs_n = 1'b1; oe_n = 1'b1;
        step(4);

        // R5: write strobe leads select, stays muted until select releases
        addr = pool[1]; din = 8'h3C; we_n = 1'b0;
        step(2);
        cs_n = 1'b0; oe_n = 1'b0;
        step(5);
        check("R5 muted while both low", 32'(dout_oe), 32'd0);
        we_n = 1'b1;
        step(5);
        check("R5 muted after write strobe release", 32'(dout_oe), 32'd0);
        cs_n = 1'b1; oe_n = 1'b1;
        step(4);
        model[pool[1]] = 8'h3C;
        do_read(pool[1], model[pool[1]], "R5 stored byte");
        // R5: tied start also mutes
        addr = pool[2]; din = 8'h77; we_n = 1'b0; cs_n = 1'b0; oe_n = 1'b0;
        step(4);
        we_n = 1'b1;
        step(5);
        check("R5 tied start muted", 32'(dout_oe), 32'd0);
        cs_n = 1'b1; oe_n = 1'b1;
        step(4);
        model[pool[2]] = 8'h77;

        // R3: data change after window closes is ignored
        addr = pool[3]; din = 8'hA1; cs_n = 1'b0; we_n = 1'b0;
        step(4);
        we_n = 1'b1;
        step(3);
        din = 8'hB2;
        step(3);
        cs_n = 1'b1;
        step(4);
        model[pool[3]] = 8'hA1;
        do_read(pool[3], 8'hA1, "R3 late data ignored");

        // R6: protect blocks writes and floats the bus
        wprot = 1'b1;
        step(3);
        do_write(pool[4], next_byte(model[pool[4]]), 0, 0);
        addr = pool[4]; cs_n = 1'b0; oe_n = 1'b0;
        step(5);
        check("R6 floats under protect", 32'(dout_oe), 32'd0);
        cs_n = 1'b1; oe_n = 1'b1;
        wprot = 1'b0;
        step(4);
        do_read(pool[4], model[pool[4]], "R6 array unchanged");

        // R7: protect aborts an open window
        addr = pool[5]; din = next_byte(model[pool[5]]); cs_n = 1'b0; we_n = 1'b0;
        step(4);
        wprot = 1'b1;
        step(4);
        wprot = 1'b0;
        step(4);
        we_n = 1'b1;
        step(2);
        cs_n = 1'b1;
        step(4);
        do_read(pool[5], model[pool[5]], "R7 aborted write");

        // R2 R3: random mix of writes and reads
        for (int k = 0; k < 150; k++) begin
            int idx;
            idx = int'($urandom % POOL);
            if ($urandom % 2 == 0) begin
                model[pool[idx]] = DW'($urandom);
                do_write(pool[idx], model[pool[idx]], int'($urandom % 3), int'($urandom % 2));
            end else begin
                do_read(pool[idx], model[pool[idx]], "R2 random read");
            end
        end

        // R2: write strobe high but output strobe high -> no drive
        addr = pool[0]; cs_n = 1'b0;
        step(5);
        check("R2 no drive without output strobe", 32'(dout_oe), 32'd0);
        check("R2 dout zero when off", 32'(dout), 32'd0);
        cs_n = 1'b1;
        step(4);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule